// File: doc/BRIEF.md
# PDM Clock Recovery from a Slave Serial Audio Port

This block is the clocking front end of a microphone-to-PCM bridge that is a slave on a serial audio port. The bit clock and frame sync come from an external host and are oversampled in a faster free-running system clock. The block counts the bit-clock rising edges between consecutive frame-sync rising edges and maps that count onto one of six supported frame lengths. It then derives a microphone clock that runs at 64 times the frame rate, whichever frame length is in use. It does this by toggling its output after a fixed number of bit-clock edges, counting both rising and falling edges.

The block also sets the start-up timeline. After reset the microphone clock appears only after a run of good frames. A separate flag marks the point at which the decimation path downstream has settled. If either input clock disappears, the block enters a power-down state and stops the microphone clock at once. When the frame length changes or a malformed frame arrives, it drops lock and relocks on its own. After the first lock, every later relock needs only a short run of frames.

The frame start is the frame-sync rising edge in every format. With two-slot framing and a 50% duty frame sync, the frame length is still measured correctly between rising edges. The block has no data stream, so its pins are plain control and status signals.

Top module: `pdm_clock_recovery`

## Requirements
- R1: While reset is held and afterwards, until the first frame-sync rising edge arrives with a live bit clock, pwr_down is 1, locked and data_valid are 0, pdm_clk is 0 and ratio_code reads 7.
- R2: A frame length of 64, 128, 192, 256, 384 or 512 bit clocks has code 0, 1, 2, 3, 4 or 5 respectively. Any other length is unsupported. While locked, ratio_code shows the code of the locked length. While not locked, it reads 7.
- R3: While locked, pdm_clk completes exactly 64 periods per frame at 50% duty. Its half period is L/64 bit-clock edges, counting both rising and falling edges, where L is the frame length. For L = 64 it follows the bit clock.
- R4: After reset, locked rises, and pdm_clk starts, at the end of the 16th consecutive complete frame with the same supported length. A frame is counted only if the first frame-sync rising edge after wake-up began it.
- R5: data_valid rises at the end of the 48th complete matching frame after locked rose, which is 64 frames after reset in total. It is 0 whenever locked is 0.
- R6: If the bit clock shows no edge for BCLK_TIMEOUT system cycles, the block enters power-down. pwr_down goes to 1, locked and data_valid go to 0, and pdm_clk is held low.
- R7: If no frame-sync rising edge arrives for FRAME_TIMEOUT system cycles while the bit clock still runs, the block enters the same power-down state.
- R8: After any earlier lock, power-down is left on the next frame-sync rising edge with a live bit clock. Lock is then regained after 4 complete matching frames, and data_valid again needs 48 more frames.
- R9: A complete frame whose supported length differs from the locked length drops lock at that frame's end and stops pdm_clk. That frame counts as the first of the 4 frames needed to relock at the new length.
- R10: A complete frame of unsupported length drops lock and resets the count of matching frames to zero. 4 further supported frames are then needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock, more than four times the bit clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial port bit clock from the host |
| fsync_in | input | 1 | Serial port frame sync from the host; rising edge starts a frame |
| pdm_clk | output | 1 | Generated microphone clock, 64 periods per frame |
| ratio_code | output | 3 | Locked frame length code (0..5), 7 when unlocked |
| locked | output | 1 | Frame length is locked and pdm_clk is running |
| data_valid | output | 1 | Downstream decimated data has settled |
| pwr_down | output | 1 | Input clocks absent; block is in its low-power state |

## Verification
The bench targets the frame counts at the edges of each window. It checks one frame before and one frame after the 16-frame start, the 48-frame data-valid point and the 4-frame relock. A counter that is off by one would move locked or data_valid by a whole frame, and the bench would see that. For every frame length, the bench counts pdm_clk rising edges and high cycles across a whole frame. A divider that got the 192 case wrong (which needs both bit-clock edges) or any other case wrong would give a count other than 64 periods or an unbalanced duty cycle. Malformed frames are placed in the middle of an acquisition run, so a design that does not clear its match count would lock too early. The bench also tests each clock loss on its own. A design that only watched one of the two clocks would never drop into power-down for the other.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [2:0] {
    RC_64   = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5,
    RC_NONE = 3'd7
  } ratio_e;

  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_ACQ  = 2'd1,
    ST_RUN  = 2'd2
  } lock_state_e;

  // Map a measured bit-clock count onto a supported frame length code.
  function automatic ratio_e classify_ratio(input logic [31:0] n);
    case (n)
      32'd64:  return RC_64;
      32'd128: return RC_128;
      32'd192: return RC_192;
      32'd256: return RC_256;
      32'd384: return RC_384;
      32'd512: return RC_512;
      default: return RC_NONE;
    endcase
  endfunction

  // Bit-clock edges (rising and falling) per half period of the microphone clock.
  function automatic logic [31:0] half_period_edges(input ratio_e c);
    case (c)
      RC_128:  return 32'd2;
      RC_192:  return 32'd3;
      RC_256:  return 32'd4;
      RC_384:  return 32'd6;
      RC_512:  return 32'd8;
      default: return 32'd1;
    endcase
  endfunction

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/pcr_ratio_meter.sv
module pcr_ratio_meter
  import pcr_pkg::*;
#(
  parameter int MAX_RATIO = 512
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bclk_rise,
  input  logic   frame_rise,
  input  logic   quiet,
  input  logic   bclk_alive,
  output logic   frame_done,
  output ratio_e frame_code
);

  localparam int CNT_MAX = 2 * MAX_RATIO - 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b0;
      frame_done <= 1'b0;
      frame_code <= RC_NONE;
    end else begin
      frame_done <= 1'b0;
      if (frame_rise) begin
        frame_done <= armed && !quiet;
        frame_code <= classify_ratio(32'(cnt));
        cnt        <= bclk_rise ? CW'(1) : '0;
        armed      <= !quiet || bclk_alive;
      end else begin
        if (quiet) armed <= 1'b0;
        if (bclk_rise && cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: a frame result is only ever reported right after a frame start
  p_done_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(frame_rise));

endmodule

// File: rtl/pcr_clock_watch.sv
module pcr_clock_watch #(
  parameter int BCLK_TIMEOUT  = 16,
  parameter int FRAME_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_edge,
  input  logic frame_rise,
  output logic bclk_alive,
  output logic frame_alive
);

  localparam int BW = $clog2(BCLK_TIMEOUT + 1);
  localparam int FW = $clog2(FRAME_TIMEOUT + 1);

  logic [BW-1:0] bidle;
  logic [FW-1:0] fidle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidle <= BW'(BCLK_TIMEOUT);
      fidle <= FW'(FRAME_TIMEOUT);
    end else begin
      if (bclk_edge)                        bidle <= '0;
      else if (bidle != BW'(BCLK_TIMEOUT))  bidle <= bidle + 1'b1;
      if (frame_rise)                       fidle <= '0;
      else if (fidle != FW'(FRAME_TIMEOUT)) fidle <= fidle + 1'b1;
    end
  end

  assign bclk_alive  = (bidle != BW'(BCLK_TIMEOUT));
  assign frame_alive = (fidle != FW'(FRAME_TIMEOUT));

  // R6: any bit-clock edge makes the clock count as present in the next cycle
  p_edge_revives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_edge |=> bclk_alive);

  // R7: a frame start makes the frame sync count as present in the next cycle
  p_rise_revives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> frame_alive);

endmodule

// File: rtl/pcr_lock_seq.sv
module pcr_lock_seq
  import pcr_pkg::*;
#(
  parameter int START_FRAMES  = 16,
  parameter int RELOCK_FRAMES = 4,
  parameter int VALID_FRAMES  = 48
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_rise,
  input  logic   frame_done,
  input  ratio_e frame_code,
  input  logic   bclk_alive,
  input  logic   frame_alive,
  output logic   quiet,
  output logic   running,
  output logic   valid,
  output ratio_e run_code
);

  localparam int ACQ_MAX = (START_FRAMES > RELOCK_FRAMES) ? START_FRAMES : RELOCK_FRAMES;
  localparam int GW      = $clog2(ACQ_MAX + 1);
  localparam int VW      = $clog2(VALID_FRAMES + 1);

  lock_state_e   state;
  logic [GW-1:0] good, good_nxt, target;
  logic [VW-1:0] vcnt;
  ratio_e        cur;
  logic          warm;

  always_comb begin
    target   = warm ? GW'(RELOCK_FRAMES) : GW'(START_FRAMES);
    good_nxt = (good == '0 || frame_code == cur) ? good + 1'b1 : GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_DOWN;
      good  <= '0;
      vcnt  <= '0;
      cur   <= RC_NONE;
      warm  <= 1'b0;
    end else if (state != ST_DOWN && !(bclk_alive && frame_alive)) begin
      state <= ST_DOWN;
      good  <= '0;
      vcnt  <= '0;
    end else begin
      case (state)
        ST_DOWN: begin
          if (frame_rise && bclk_alive) begin
            state <= ST_ACQ;
            good  <= '0;
          end
        end
        ST_ACQ: begin
          if (frame_done) begin
            if (frame_code == RC_NONE) begin
              good <= '0;
            end else begin
              cur <= frame_code;
              if (good_nxt >= target) begin
                state <= ST_RUN;
                good  <= '0;
                vcnt  <= '0;
                warm  <= 1'b1;
              end else begin
                good <= good_nxt;
              end
            end
          end
        end
        ST_RUN: begin
          if (frame_done) begin
            if (frame_code == RC_NONE) begin
              state <= ST_ACQ;
              good  <= '0;
            end else if (frame_code != cur) begin
              state <= ST_ACQ;
              good  <= GW'(1);
              cur   <= frame_code;
            end else if (vcnt != VW'(VALID_FRAMES)) begin
              vcnt <= vcnt + 1'b1;
            end
          end
        end
        default: state <= ST_DOWN;
      endcase
    end
  end

  assign quiet    = (state == ST_DOWN);
  assign running  = (state == ST_RUN);
  assign valid    = running && (vcnt == VW'(VALID_FRAMES));
  assign run_code = running ? cur : RC_NONE;

  // R4: lock is only ever taken on a completed frame
  p_lock_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(frame_done));

  // R5: the settled flag only ever rises on a completed frame
  p_valid_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(frame_done));

  // R8: power-down is left only on a frame start with a live bit clock
  p_wake_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiet) |-> $past(frame_rise && bclk_alive));

  // R10: a malformed frame ends lock
  p_bad_frame_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && frame_done && frame_code == RC_NONE) |=> !running);

  // R9: a frame of another supported length ends lock
  p_new_length_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && frame_done && frame_code != RC_NONE && frame_code != cur
     && bclk_alive && frame_alive) |=> !running);

endmodule

// File: rtl/pcr_pdm_divider.sv
module pcr_pdm_divider
  import pcr_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   bclk_edge,
  input  ratio_e code,
  output logic   pdm
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = DIV_W'(half_period_edges(code) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pdm <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      pdm <= 1'b0;
    end else if (bclk_edge) begin
      if (cnt >= last) begin
        cnt <= '0;
        pdm <= ~pdm;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the output moves only on a bit-clock edge while running
  p_toggle_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bclk_edge) |=> $stable(pdm));

endmodule

// File: rtl/pdm_clock_recovery.sv
module pdm_clock_recovery
  import pcr_pkg::*;
#(
  parameter int MAX_RATIO     = 512,
  parameter int SYNC_STAGES   = 2,
  parameter int START_FRAMES  = 16,
  parameter int RELOCK_FRAMES = 4,
  parameter int VALID_FRAMES  = 48,
  parameter int BCLK_TIMEOUT  = 16,
  parameter int FRAME_TIMEOUT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_in,
  input  logic       fsync_in,
  output logic       pdm_clk,
  output logic [2:0] ratio_code,
  output logic       locked,
  output logic       data_valid,
  output logic       pwr_down
);

  localparam int DIV_W = $clog2(MAX_RATIO / 64 + 1);

  logic [1:0] raw, synced, prev;
  logic       bclk_rise, bclk_edge, frame_rise;
  logic       bclk_alive, frame_alive;
  logic       frame_done, quiet, running, valid;
  ratio_e     frame_code, run_code;

  assign raw = {fsync_in, bclk_in};

  pcr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= synced;
  end

  assign bclk_rise  = synced[0] & ~prev[0];
  assign bclk_edge  = synced[0] ^ prev[0];
  assign frame_rise = synced[1] & ~prev[1];

  pcr_clock_watch #(.BCLK_TIMEOUT(BCLK_TIMEOUT), .FRAME_TIMEOUT(FRAME_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_n), .bclk_edge(bclk_edge), .frame_rise(frame_rise),
    .bclk_alive(bclk_alive), .frame_alive(frame_alive)
  );

  pcr_ratio_meter #(.MAX_RATIO(MAX_RATIO)) u_meter (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .frame_rise(frame_rise),
    .quiet(quiet), .bclk_alive(bclk_alive),
    .frame_done(frame_done), .frame_code(frame_code)
  );

  pcr_lock_seq #(
    .START_FRAMES(START_FRAMES), .RELOCK_FRAMES(RELOCK_FRAMES), .VALID_FRAMES(VALID_FRAMES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_rise(frame_rise), .frame_done(frame_done),
    .frame_code(frame_code), .bclk_alive(bclk_alive), .frame_alive(frame_alive),
    .quiet(quiet), .running(running), .valid(valid), .run_code(run_code)
  );

  pcr_pdm_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(running), .bclk_edge(bclk_edge),
    .code(run_code), .pdm(pdm_clk)
  );

  assign ratio_code = run_code;
  assign locked     = running;
  assign data_valid = valid;
  assign pwr_down   = quiet;

  // R6: in power-down the microphone clock is held low
  p_quiet_holds_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !pdm_clk);

  // R2: a locked state always carries a supported code
  p_locked_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_code != RC_NONE));

endmodule

// File: tb/sim_pdm_clock_recovery.sv
module sim_pdm_clock_recovery;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic       pdm_clk;
  logic [2:0] ratio_code;
  logic       locked, data_valid, pwr_down;

  always #4 clk = ~clk;

  pdm_clock_recovery u0 (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fsync),
    .pdm_clk(pdm_clk), .ratio_code(ratio_code), .locked(locked),
    .data_valid(data_valid), .pwr_down(pwr_down)
  );

  int checks = 0;
  int errors = 0;

  logic meas_en = 1'b0;
  logic pdm_prev = 1'b0;
  int   pdm_rises = 0;
  int   pdm_high = 0;

  always @(posedge clk) begin
    if (meas_en) begin
      if (pdm_clk && !pdm_prev) pdm_rises++;
      if (pdm_clk) pdm_high++;
    end
    pdm_prev <= pdm_clk;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_status(input string req, input int lk, input int dv, input int pd, input int code);
    check_eq(req, "locked", int'(locked), lk);
    check_eq(req, "data_valid", int'(data_valid), dv);
    check_eq(req, "pwr_down", int'(pwr_down), pd);
    check_eq(req, "ratio_code", int'(ratio_code), code);
  endtask

  // one bit clock: low half then high half, 3 system cycles each
  task automatic drive_bit(input logic fs);
    @(negedge clk); bclk = 1'b0; fsync = fs;
    repeat (2) @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0);
  endtask

  task automatic run_frames(input int r, input int n);
    for (int f = 0; f < n; f++)
      for (int b = 0; b < r; b++)
        drive_bit((r == 64) ? (b < 32) : (b == 0));
  endtask

  task automatic meas(input int r, input string req);
    pdm_rises = 0;
    pdm_high  = 0;
    meas_en   = 1'b1;
    run_frames(r, 1);
    meas_en   = 1'b0;
    check_eq(req, "pdm periods per frame", pdm_rises, 64);
    check_eq(req, "pdm high cycles per frame", pdm_high, r * 3);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check_status("R1", 0, 0, 1, 7);
    check_eq("R1", "pdm_clk in reset", int'(pdm_clk), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_status("R1", 0, 0, 1, 7);
    check_eq("R1", "pdm_clk after reset", int'(pdm_clk), 0);
  endtask

  task automatic t_first_lock();
    idle_bits(8);
    run_frames(64, 16);               // 15 complete frames
    check_status("R4", 0, 0, 0, 7);
    check_eq("R4", "pdm_clk before lock", int'(pdm_clk), 0);
    run_frames(64, 1);                // 16th frame complete
    check_status("R4", 1, 0, 0, 0);
    meas(64, "R3");
    run_frames(64, 46);               // 47 frames since lock
    check_status("R5", 1, 0, 0, 0);
    run_frames(64, 1);                // 48 frames since lock
    check_status("R5", 1, 1, 0, 0);
  endtask

  task automatic t_change(input int r, input int code);
    run_frames(r, 1);                 // old length frame closes
    check_eq("R9", "still locked on old length", int'(locked), 1);
    run_frames(r, 1);                 // first new-length frame closes
    check_status("R9", 0, 0, 0, 7);
    run_frames(r, 2);
    check_eq("R9", "locked after 3 new frames", int'(locked), 0);
    run_frames(r, 1);
    check_status("R2", 1, 0, 0, code);
    meas(r, "R3");
  endtask

  task automatic t_bad_ratio();
    run_frames(300, 1);
    run_frames(128, 3);               // malformed frame closed, then 2 good
    check_status("R10", 0, 0, 0, 7);
    run_frames(300, 1);               // 3rd good frame closes
    run_frames(128, 1);               // malformed frame closes: count to zero
    check_eq("R10", "locked after malformed frame", int'(locked), 0);
    run_frames(128, 3);               // 3 good frames
    check_eq("R10", "locked after 3 good frames", int'(locked), 0);
    run_frames(128, 1);               // 4th good frame
    check_status("R10", 1, 0, 0, 1);
  endtask

  task automatic t_bclk_loss();
    int highs;
    @(negedge clk); bclk = 1'b0; fsync = 1'b0;
    repeat (40) @(negedge clk);
    check_status("R6", 0, 0, 1, 7);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pdm_clk) highs++;
    end
    check_eq("R6", "pdm high samples while stopped", highs, 0);
    idle_bits(8);
    run_frames(256, 4);
    check_status("R8", 0, 0, 0, 7);
    run_frames(256, 1);
    check_status("R8", 1, 0, 0, 3);
    meas(256, "R3");
  endtask

  task automatic t_frame_loss();
    idle_bits(800);
    check_status("R7", 0, 0, 1, 7);
    check_eq("R7", "pdm_clk after frame loss", int'(pdm_clk), 0);
    run_frames(64, 4);
    check_status("R8", 0, 0, 0, 7);
    run_frames(64, 1);
    check_status("R8", 1, 0, 0, 0);
    meas(64, "R3");
  endtask

  task automatic run_all();
    t_reset();
    t_first_lock();
    t_change(128, 1);
    t_change(192, 2);
    t_change(256, 3);
    t_change(384, 4);
    t_change(512, 5);
    t_bad_ratio();
    t_bclk_loss();
    t_frame_loss();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule